// File: doc/BRIEF.md
# Double-Buffered Backlight PWM Generator

This block drives one display backlight line with a pulse-width-modulated signal. Software programs three things through a small synchronous register port: a clock prescaler, a cycle length and a high width. The prescaler sets how many input clocks form one PWM tick. The cycle length is counted in ticks. The output is high for the first high-width ticks of every cycle. A single control register holds the run enable, a bypass switch and a commit bit.

Every software write lands in a shadow copy. The generator itself runs from a separate working copy. With bypass off, software writes the new values and then pulses the commit bit (writes it as 1 and then as 0). The working copy takes the shadow values at the next cycle boundary. With bypass on, the working copy follows the shadow at every cycle boundary, so no commit is needed. In both modes, a cycle that has already started always runs to its end with the values it started with. While the generator is stopped, every clock counts as a boundary.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset, `pwm_o` is low and a read of each of the three registers returns zero.
- R2: Register map, with word addresses on `reg_addr`. Address 0 is control: bit 0 is run enable, bit 1 is bypass and bit 2 is commit. Address 1 holds the prescaler in bits 25:16. Address 2 holds the cycle length in bits 11:0 and the high width in bits 28:16. A read returns the shadow values, and all other bits read as zero whatever was written to them.
- R3: One tick lasts (prescaler+1) clocks. One PWM cycle lasts (length+1) ticks. While running, the output is high for the first high-width ticks of each cycle.
- R4: When the high width is larger than the cycle length, the output is high for the whole cycle, so it stays high without a break.
- R5: When the high width is zero, the output stays low.
- R6: With bypass off, writes to the prescaler and timing registers do not change the running waveform until a commit is made.
- R7: Writing control with commit set and then with commit clear copies the shadow prescaler, length and width into the working copy at the next cycle boundary.
- R8: The working copy changes only at a cycle boundary. The cycle that is running when a commit is made completes with its full old length and width.
- R9: With bypass on, shadow values take effect at the next cycle boundary without a commit.
- R10: While run enable is clear, the output is low and both counters are held at zero. Setting the bit starts a full cycle from its first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 4 | Word address for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational from the shadow registers |
| pwm_o | output | 1 | PWM output |

## Verification
The waveform is measured from one rising edge to the next, and each measured period and high time is compared with the value (length+1)(prescaler+1) and width(prescaler+1) worked out from the settings. The bench uses a plain setting with no prescaler and then a setting with a prescaler. It switches to new values in the middle of a cycle: a first cycle with the old values shows that the running cycle was neither cut short nor changed by shadow writes, and the cycles after it show that the commit took effect. Width settings above the length, equal to length+1, and zero should each hold the output at one level, and the bench checks that it does. Two further cases show when values take effect: bypass mode, where new values apply without a commit, and a restart after disable, where the first pulse must have its full width.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  parameter int unsigned DATA_W   = 32;
  parameter int unsigned ADDR_W   = 4;
  parameter int unsigned PRESC_W  = 10;
  parameter int unsigned PERIOD_W = 12;
  parameter int unsigned HIGH_W   = 13;

  parameter int unsigned PRESC_LSB  = 16;
  parameter int unsigned PERIOD_LSB = 0;
  parameter int unsigned HIGH_LSB   = 16;

  parameter int unsigned EN_BIT  = 0;
  parameter int unsigned BYP_BIT = 1;
  parameter int unsigned CMT_BIT = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_PRESC = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_TIME  = ADDR_W'(2);

  typedef struct packed {
    logic [PRESC_W-1:0]  presc;
    logic [PERIOD_W-1:0] period;
    logic [HIGH_W-1:0]   high;
  } cfg_t;
endpackage

// File: rtl/bl_pwm_rst_sync.sv
module bl_pwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              run_en,
  output logic              bypass,
  output cfg_t              shadow,
  output logic              commit_evt
);
  logic wr_ctrl, wr_presc, wr_time;
  logic en_q, byp_q, cmt_q, evt_q;
  logic en_nxt, byp_nxt, cmt_nxt, evt_nxt;
  logic [PRESC_W-1:0]  presc_q, presc_nxt;
  logic [PERIOD_W-1:0] period_q, period_nxt;
  logic [HIGH_W-1:0]   high_q, high_nxt;

  // write decode and next-state values
  always_comb begin
    wr_ctrl    = we && (addr == ADDR_CTRL);
    wr_presc   = we && (addr == ADDR_PRESC);
    wr_time    = we && (addr == ADDR_TIME);
    en_nxt     = wdata[EN_BIT];
    byp_nxt    = wdata[BYP_BIT];
    cmt_nxt    = wdata[CMT_BIT];
    presc_nxt  = wdata[PRESC_LSB +: PRESC_W];
    period_nxt = wdata[PERIOD_LSB +: PERIOD_W];
    high_nxt   = wdata[HIGH_LSB +: HIGH_W];
    // commit fires when the stored bit goes from one to zero
    evt_nxt    = wr_ctrl && !wdata[CMT_BIT] && cmt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      byp_q <= 1'b0;
      cmt_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q  <= en_nxt;
      byp_q <= byp_nxt;
      cmt_q <= cmt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
    end else if (wr_presc) begin
      presc_q <= presc_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      high_q   <= '0;
    end else if (wr_time) begin
      period_q <= period_nxt;
      high_q   <= high_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
    end else begin
      evt_q <= evt_nxt;
    end
  end

  // read-back of shadow values, unused bits zero
  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_CTRL: begin
        rdata[EN_BIT]  = en_q;
        rdata[BYP_BIT] = byp_q;
        rdata[CMT_BIT] = cmt_q;
      end
      ADDR_PRESC: rdata[PRESC_LSB +: PRESC_W] = presc_q;
      ADDR_TIME: begin
        rdata[PERIOD_LSB +: PERIOD_W] = period_q;
        rdata[HIGH_LSB +: HIGH_W]     = high_q;
      end
      default: rdata = '0;
    endcase
  end

  assign run_en        = en_q;
  assign bypass        = byp_q;
  assign shadow.presc  = presc_q;
  assign shadow.period = period_q;
  assign shadow.high   = high_q;
  assign commit_evt    = evt_q;
endmodule

// File: rtl/bl_pwm_load.sv
module bl_pwm_load
  import bl_pwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t shadow,
  input  logic commit_evt,
  input  logic bypass,
  input  logic bound,
  output cfg_t work
);
  logic pend_q, pend_nxt, load;
  cfg_t work_q;

  always_comb begin
    load     = bound && (pend_q || bypass);
    pend_nxt = commit_evt || (pend_q && !load);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
    end else if (load) begin
      work_q <= shadow;
    end
  end

  assign work = work_q;
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  cfg_t                work,
  output logic                pwm,
  output logic                bound,
  output logic [PRESC_W-1:0]  pre_cnt,
  output logic [PERIOD_W-1:0] cyc_cnt
);
  logic [PRESC_W-1:0]  pre_q, pre_nxt;
  logic [PERIOD_W-1:0] cyc_q, cyc_nxt;
  logic tick_end, cyc_end;

  always_comb begin
    tick_end = (pre_q == work.presc);
    cyc_end  = tick_end && (cyc_q == work.period);
    if (!run_en || tick_end) begin
      pre_nxt = '0;
    end else begin
      pre_nxt = pre_q + 1'b1;
    end
    if (!run_en || cyc_end) begin
      cyc_nxt = '0;
    end else if (tick_end) begin
      cyc_nxt = cyc_q + 1'b1;
    end else begin
      cyc_nxt = cyc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cyc_q <= '0;
    end else begin
      pre_q <= pre_nxt;
      cyc_q <= cyc_nxt;
    end
  end

  assign bound   = !run_en || cyc_end;
  assign pwm     = run_en && (HIGH_W'(cyc_q) < work.high);
  assign pre_cnt = pre_q;
  assign cyc_cnt = cyc_q;
endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
  import bl_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_o
);
  logic rst_n_s, run_en, bypass, commit_evt, bound;
  cfg_t shadow_cfg, work_cfg;
  logic [PRESC_W-1:0]  pre_cnt;
  logic [PERIOD_W-1:0] cyc_cnt;

  bl_pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_a(rst_n), .rst_n_s(rst_n_s)
  );

  bl_pwm_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .run_en(run_en),
    .bypass(bypass), .shadow(shadow_cfg), .commit_evt(commit_evt)
  );

  bl_pwm_load u_load (
    .clk(clk), .rst_n(rst_n_s), .shadow(shadow_cfg),
    .commit_evt(commit_evt), .bypass(bypass), .bound(bound),
    .work(work_cfg)
  );

  bl_pwm_core u_core (
    .clk(clk), .rst_n(rst_n_s), .run_en(run_en), .work(work_cfg),
    .pwm(pwm_o), .bound(bound), .pre_cnt(pre_cnt), .cyc_cnt(cyc_cnt)
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk
  import bl_pwm_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                run_en,
  input logic                bound,
  input logic                pwm,
  input cfg_t                work,
  input logic [PRESC_W-1:0]  pre_cnt,
  input logic [PERIOD_W-1:0] cyc_cnt
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_cnt <= work.period) && (pre_cnt <= work.presc)); // R3

  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && (work.high > HIGH_W'(work.period))) |-> pwm); // R4

  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (work.high == '0) |-> !pwm); // R5

  AST_LOAD_AT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(work) |-> $past(bound)); // R8

  AST_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !pwm); // R10

  AST_CNT_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (pre_cnt == '0) && (cyc_cnt == '0)); // R10
endmodule

bind bl_pwm_top bl_pwm_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .run_en(run_en), .bound(bound),
  .pwm(pwm_o), .work(work_cfg), .pre_cnt(pre_cnt), .cyc_cnt(cyc_cnt)
);

// File: tb/sim_bl_pwm_top.sv
module sim_bl_pwm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwm_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bl_pwm_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_o(pwm_o)
  );

  // scoreboard: expected period/high in clocks per measured cycle
  int    exp_per[$];
  int    exp_hi[$];
  string exp_tag[$];
  logic  arm = 1'b0;
  bit    have_prev = 1'b0;
  logic  last = 1'b0;
  int    m_per = 0;
  int    m_hi = 0;

  always @(negedge clk) begin
    if (arm) begin
      if (pwm_o && !last) begin
        if (have_prev && exp_per.size() > 0) begin
          int ep, eh;
          string tg;
          ep = exp_per.pop_front();
          eh = exp_hi.pop_front();
          tg = exp_tag.pop_front();
          checks++;
          if (m_per != ep || m_hi != eh) begin
            errors++;
            $display("FAIL %s: period/high %0d/%0d expected %0d/%0d", tg, m_per, m_hi, ep, eh);
          end
        end
        have_prev = 1'b1;
        m_per = 1;
        m_hi = 1;
      end else if (have_prev) begin
        m_per++;
        if (pwm_o) m_hi++;
      end
    end else begin
      have_prev = 1'b0;
    end
    last = pwm_o;
  end

  task automatic push_exp(input int per, input int hi, input string tag);
    exp_per.push_back(per);
    exp_hi.push_back(hi);
    exp_tag.push_back(tag);
  endtask

  task automatic drain();
    wait (exp_per.size() == 0);
    @(negedge clk);
    arm = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s: read addr %0d got %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic hold_check(input logic lvl, input int n, input string tag);
    int bad = 0;
    logic seen = lvl;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_o !== lvl) begin
        bad++;
        seen = pwm_o;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: pwm_o %b in %0d samples expected %b", tag, seen, bad, lvl);
    end
  endtask

  task automatic commit(input logic [31:0] base);
    wr(4'd0, base | 32'h4);
    wr(4'd0, base);
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_sim();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    checks++;
    if (pwm_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: pwm_o %b expected 0", pwm_o);
    end
    rd_check(4'd0, 32'h0, "R1");
    rd_check(4'd1, 32'h0, "R1");
    rd_check(4'd2, 32'h0, "R1");

    // R2 field placement and reserved bits
    wr(4'd1, 32'hFFFF_FFFF);
    rd_check(4'd1, 32'h03FF_0000, "R2");
    wr(4'd2, 32'hFFFF_FFFF);
    rd_check(4'd2, 32'h1FFF_0FFF, "R2");
    wr(4'd0, 32'hFFFF_FFFA);
    rd_check(4'd0, 32'h0000_0002, "R2");
    wr(4'd0, 32'h0);

    // R3 R10 basic waveform from enable: presc 0, length 9, width 3
    wr(4'd1, 32'h0);
    wr(4'd2, (32'd3 << 16) | 32'd9);
    commit(32'h0);
    push_exp(10, 3, "R3 R10");
    push_exp(10, 3, "R3");
    arm = 1'b1;
    wr(4'd0, 32'h1);
    drain();

    // R6 R7 R8: shadow writes then commit mid-cycle; presc 2, length 3, width 2
    wr(4'd1, 32'd2 << 16);
    wr(4'd2, (32'd2 << 16) | 32'd3);
    push_exp(10, 3, "R6 R8");
    push_exp(12, 6, "R7 R3");
    push_exp(12, 6, "R7");
    arm = 1'b1;
    wait (have_prev);
    commit(32'h1);
    drain();

    // R4 R9 full duty in bypass mode
    wr(4'd0, 32'h3);
    wr(4'd2, (32'd6 << 16) | 32'd4);
    repeat (40) @(negedge clk);
    hold_check(1'b1, 30, "R4 R9");
    wr(4'd2, (32'd5 << 16) | 32'd4);
    repeat (40) @(negedge clk);
    hold_check(1'b1, 30, "R4");

    // R5 zero duty
    wr(4'd2, 32'd4);
    repeat (40) @(negedge clk);
    hold_check(1'b0, 30, "R5");

    // R9 bypass pulse: length 5, width 1, presc 2
    wr(4'd2, (32'd1 << 16) | 32'd5);
    push_exp(18, 3, "R9");
    push_exp(18, 3, "R9");
    arm = 1'b1;
    drain();

    // R10 disable then restart
    wr(4'd0, 32'h0);
    hold_check(1'b0, 30, "R10");
    push_exp(18, 3, "R10");
    arm = 1'b1;
    wr(4'd0, 32'h1);
    drain();

    finish_sim();
  end
endmodule